// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block sits between a warp's load/store issue stage and the global memory path. It takes one request for the whole warp: 32 lanes, an activity mask, and one word address per lane. It then splits the request into the fewest cache-line transactions that cover every active lane. Each transaction carries the line address and the set of lanes it serves. Transactions leave one per cycle over a valid/ready handshake, and downstream backpressure stalls the block without losing or changing anything.

A line holds 32 words (128 bytes of 4-byte words), so a lane's line is its word address shifted right by five. The lowest-numbered lane that is still unserved leads each transaction, and every remaining active lane on the same line joins it. After the final transaction is handed off, the block pulses a completion flag together with the number of transactions the warp needed. Only then does it accept the next warp. Unit-stride warps collapse to one or two transactions. A stride of 32 words gives one transaction for every active lane.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready is 1 and txn_valid and done are 0.
- R2: A transaction's txn_lanes holds every unserved active lane whose line (word address >> 5) equals txn_line, and no other lane.
- R3: Transactions are issued in order of the lowest-numbered unserved active lane, and no lane is served twice.
- R4: A lane whose req_mask bit is 0 never appears in any txn_lanes, even when its address shares a line with an active lane.
- R5: Thirty-two active lanes at unit stride give one transaction when the base is line-aligned and two transactions when the base is 16 words into a line.
- R6: At a stride of 32 words, each active lane gets a transaction of its own, so the count equals the number of active lanes.
- R7: txn_last is 1 on the final transaction of a warp and 0 on every earlier one.
- R8: While txn_valid is 1 and txn_ready is 0, txn_valid, txn_line, txn_lanes and txn_last hold steady.
- R9: req_ready is 0 from the cycle after a non-empty request is accepted until the final transaction's handshake.
- R10: done pulses for one cycle after the final handshake, with done_count equal to the number of transactions. An all-zero mask produces no transaction, and done pulses with a count of 0 in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_mask | input | LANES | Active-lane mask |
| req_addr | input | LANES*ADDR_W | Word addresses, lane i at bits i*ADDR_W upward |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_line | output | ADDR_W-LINE_OFS_W | Line address of the transaction |
| txn_lanes | output | LANES | Lanes served by the transaction |
| txn_last | output | 1 | Final transaction of the warp |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | clog2(LANES+1) | Transactions the finished warp needed |

## Verification
The bench drives several address patterns, and each one separates a different kind of grouping error. Aligned unit stride must collapse to a single line, and misaligned unit stride must split at the line boundary. Full and sparse 32-word strides must give one transaction per active lane. Two interleaved lines test leader order. In another pattern, inactive lanes share a line with active ones, which catches a design that ignores the mask. The empty mask tests the zero-count completion path. Downstream stalls during several of these runs confirm that the outputs stay stable and that no new request is admitted mid-warp.

// File: rtl/coal_pkg.sv
package coal_pkg;
   typedef enum logic {
      CS_IDLE  = 1'b0,
      CS_ISSUE = 1'b1
   } coal_state_e;
endpackage

// File: rtl/lane_first_pick.sv
module lane_first_pick #(
   parameter int N     = 32,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = i[IDX_W-1:0];
         end
      end
   end
endmodule

// File: rtl/line_group.sv
module line_group #(
   parameter int LANES      = 32,
   parameter int ADDR_W     = 32,
   parameter int LINE_OFS_W = 5,
   localparam int IDX_W     = $clog2(LANES),
   localparam int LINE_W    = ADDR_W - LINE_OFS_W
) (
   input  logic [LANES*ADDR_W-1:0] addr,
   input  logic [LANES-1:0]        pending,
   input  logic [IDX_W-1:0]        lead,
   output logic [LINE_W-1:0]       lead_line,
   output logic [LANES-1:0]        match
);
   logic [LINE_W-1:0] line_of [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign line_of[g] = addr[g*ADDR_W + LINE_OFS_W +: LINE_W];
   end

   assign lead_line = line_of[lead];

   for (genvar g = 0; g < LANES; g++) begin : g_cmp
      assign match[g] = pending[g] && (line_of[g] == lead_line);
   end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
   import coal_pkg::*;
#(
   parameter int LANES      = 32,
   parameter int ADDR_W     = 32,
   parameter int LINE_OFS_W = 5,
   localparam int IDX_W     = $clog2(LANES),
   localparam int CNT_W     = $clog2(LANES + 1),
   localparam int LINE_W    = ADDR_W - LINE_OFS_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [LANES-1:0]        req_mask,
   input  logic [LANES*ADDR_W-1:0] req_addr,
   output logic                    txn_valid,
   input  logic                    txn_ready,
   output logic [LINE_W-1:0]       txn_line,
   output logic [LANES-1:0]        txn_lanes,
   output logic                    txn_last,
   output logic                    done,
   output logic [CNT_W-1:0]        done_count
);
   if (LANES < 2 || (1 << IDX_W) != LANES) begin : g_bad_lanes
      $error("warp_coalescer: LANES must be a power of two, at least 2");
   end
   if (LINE_OFS_W < 0 || LINE_OFS_W >= ADDR_W) begin : g_bad_ofs
      $error("warp_coalescer: LINE_OFS_W must lie below ADDR_W");
   end

   coal_state_e             state_q;
   logic [LANES-1:0]        pend_q;
   logic [LANES*ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]        cnt_q;
   logic                    done_q;
   logic [CNT_W-1:0]        done_cnt_q;

   logic                    lead_found;
   logic [IDX_W-1:0]        lead_idx;
   logic [LINE_W-1:0]       lead_line;
   logic [LANES-1:0]        grp_mask;
   logic                    accept;
   logic                    hand_off;
   logic                    final_txn;

   lane_first_pick #(.N(LANES), .IDX_W(IDX_W)) u_pick (
      .req   (pend_q),
      .found (lead_found),
      .idx   (lead_idx)
   );

   line_group #(.LANES(LANES), .ADDR_W(ADDR_W), .LINE_OFS_W(LINE_OFS_W)) u_group (
      .addr      (addr_q),
      .pending   (pend_q),
      .lead      (lead_idx),
      .lead_line (lead_line),
      .match     (grp_mask)
   );

   assign req_ready = (state_q == CS_IDLE);
   assign accept    = req_valid && req_ready;
   assign txn_valid = (state_q == CS_ISSUE) && lead_found;
   assign txn_line  = lead_line;
   assign txn_lanes = grp_mask;
   assign final_txn = ((pend_q & ~grp_mask) == '0);
   assign txn_last  = final_txn;
   assign hand_off  = txn_valid && txn_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= CS_IDLE;
         pend_q     <= '0;
         addr_q     <= '0;
         cnt_q      <= '0;
         done_q     <= 1'b0;
         done_cnt_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            addr_q <= req_addr;
            pend_q <= req_mask;
            cnt_q  <= '0;
            if (req_mask == '0) begin
               done_q     <= 1'b1;
               done_cnt_q <= '0;
            end else begin
               state_q <= CS_ISSUE;
            end
         end else if (hand_off) begin
            pend_q <= pend_q & ~grp_mask;
            cnt_q  <= cnt_q + CNT_W'(1);
            if (final_txn) begin
               state_q    <= CS_IDLE;
               done_q     <= 1'b1;
               done_cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   assign done       = done_q;
   assign done_count = done_cnt_q;
endmodule

// File: rtl/warp_coalescer_checker.sv
module warp_coalescer_checker #(
   parameter int LANES      = 32,
   parameter int ADDR_W     = 32,
   parameter int LINE_OFS_W = 5,
   localparam int CNT_W     = $clog2(LANES + 1),
   localparam int LINE_W    = ADDR_W - LINE_OFS_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [LANES-1:0]  req_mask,
   input logic              txn_valid,
   input logic              txn_ready,
   input logic [LINE_W-1:0] txn_line,
   input logic [LANES-1:0]  txn_lanes,
   input logic              txn_last,
   input logic              done,
   input logic [CNT_W-1:0]  done_count
);
   logic [LANES-1:0] seen_mask;
   logic [LANES-1:0] served;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_mask <= '0;
         served    <= '0;
      end else if (req_valid && req_ready) begin
         seen_mask <= req_mask;
         served    <= '0;
      end else if (txn_valid && txn_ready) begin
         served <= served | txn_lanes;
      end
   end

   a_r9_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> !req_ready);

   a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_line)
                                     && $stable(txn_lanes) && $stable(txn_last)));

   a_r4_only_active: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> ((txn_lanes & ~seen_mask) == '0 && txn_lanes != '0));

   a_r3_no_reserve: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> ((txn_lanes & served) == '0));

   a_r10_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_ready && txn_last) |=> (done && done_count != '0));

   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind warp_coalescer warp_coalescer_checker #(
   .LANES(LANES), .ADDR_W(ADDR_W), .LINE_OFS_W(LINE_OFS_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_mask(req_mask), .txn_valid(txn_valid), .txn_ready(txn_ready),
   .txn_line(txn_line), .txn_lanes(txn_lanes), .txn_last(txn_last),
   .done(done), .done_count(done_count)
);

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;
   localparam int LANES = 32;
   localparam int AW    = 32;
   localparam int OFS   = 5;
   localparam int LW    = AW - OFS;
   localparam int CW    = $clog2(LANES + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [LANES-1:0] req_mask = '0;
   logic [LANES*AW-1:0] req_addr = '0;
   logic             txn_valid;
   logic             txn_ready = 1'b1;
   logic [LW-1:0]    txn_line;
   logic [LANES-1:0] txn_lanes;
   logic             txn_last;
   logic             done;
   logic [CW-1:0]    done_count;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   warp_coalescer #(.LANES(LANES), .ADDR_W(AW), .LINE_OFS_W(OFS)) i_warp_coalescer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_mask(req_mask), .req_addr(req_addr), .txn_valid(txn_valid),
      .txn_ready(txn_ready), .txn_line(txn_line), .txn_lanes(txn_lanes),
      .txn_last(txn_last), .done(done), .done_count(done_count)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Drives one warp and checks every transaction against the grouping rule:
   // leader = lowest unserved active lane, group = unserved lanes on leader's line.
   task automatic run_warp(input string name, input logic [LANES-1:0] mask,
                           input logic [LANES*AW-1:0] addrs, input bit stall,
                           input int exp_n);
      logic [LANES-1:0] left;
      int n;
      @(negedge clk);
      req_valid = 1'b1;
      req_mask  = mask;
      req_addr  = addrs;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      left = mask;
      n = 0;
      while (left != '0) begin
         int lead;
         logic [LW-1:0] ln;
         logic [LANES-1:0] grp;
         lead = -1;
         for (int i = 0; i < LANES; i++) if (left[i] && lead < 0) lead = i;
         ln  = addrs[lead*AW + OFS +: LW];
         grp = '0;
         for (int i = 0; i < LANES; i++)
            if (left[i] && addrs[i*AW + OFS +: LW] == ln) grp[i] = 1'b1;
         left = left & ~grp;
         n++;
         check({name, " R2 valid"}, 64'(txn_valid), 64'd1);
         check({name, " R2 line"}, 64'(txn_line), 64'(ln));
         check({name, " R3 lanes"}, 64'(txn_lanes), 64'(grp));
         check({name, " R7 last"}, 64'(txn_last), 64'(left == '0));
         check({name, " R9 busy"}, 64'(req_ready), 64'd0);
         if (stall && n % 2 == 1) begin
            txn_ready = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check({name, " R8 hold lanes"}, 64'(txn_lanes), 64'(grp));
            check({name, " R8 hold valid"}, 64'(txn_valid), 64'd1);
            txn_ready = 1'b1;
         end
         @(posedge clk);
         @(negedge clk);
      end
      check({name, " R6 count model"}, 64'(n), 64'(exp_n));
      check({name, " R10 done"}, 64'(done), 64'd1);
      check({name, " R10 count"}, 64'(done_count), 64'(exp_n));
      check({name, " R9 ready again"}, 64'(req_ready), 64'd1);
      check({name, " R7 idle"}, 64'(txn_valid), 64'd0);
      @(negedge clk);
      check({name, " R10 pulse"}, 64'(done), 64'd0);
   endtask

   function automatic logic [LANES*AW-1:0] strided(input int base, input int stride);
      logic [LANES*AW-1:0] v;
      for (int i = 0; i < LANES; i++) v[i*AW +: AW] = AW'(base + i * stride);
      return v;
   endfunction

   task automatic t_reset();
      check("R1 ready", 64'(req_ready), 64'd1);
      check("R1 valid", 64'(txn_valid), 64'd0);
      check("R1 done", 64'(done), 64'd0);
   endtask

   task automatic t_unit_stride();
      run_warp("R5 aligned", '1, strided(32'h400, 1), 1'b0, 1);
      run_warp("R5 offset", '1, strided(32'h410, 1), 1'b1, 2);
   endtask

   task automatic t_big_stride();
      run_warp("R6 full", '1, strided(32'h1000, 32), 1'b1, 32);
      run_warp("R6 sparse", 32'h5555_5555, strided(32'h40, 32), 1'b0, 16);
   endtask

   task automatic t_interleave();
      logic [LANES*AW-1:0] v;
      for (int i = 0; i < LANES; i++)
         v[i*AW +: AW] = (i % 2 == 0) ? AW'(32'h2000 + i) : AW'(32'h800 + i);
      run_warp("R3 interleave", '1, v, 1'b1, 2);
   endtask

   task automatic t_inactive();
      logic [LANES*AW-1:0] v;
      for (int i = 0; i < LANES; i++)
         v[i*AW +: AW] = (i < 8) ? AW'(32'h100 + i) : AW'(32'h300 + 32 * i);
      // lanes 0-7 share one line; lane 8..31 distinct lines; only 0,2,4 and 9 active
      run_warp("R4 masked", 32'h0000_0215, v, 1'b0, 2);
   endtask

   task automatic t_empty();
      @(negedge clk);
      req_valid = 1'b1;
      req_mask  = '0;
      req_addr  = strided(0, 1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 empty done", 64'(done), 64'd1);
      check("R10 empty count", 64'(done_count), 64'd0);
      check("R10 empty no txn", 64'(txn_valid), 64'd0);
      check("R10 empty ready", 64'(req_ready), 64'd1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unit_stride();
      t_big_stride();
      t_interleave();
      t_inactive();
      t_empty();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule